// File: doc/BRIEF.md
# One-Shot Match Timer

This block is a memory-mapped system timer holding a 32-bit count, a single match register, a one-bit status flag and a 32-bit interrupt enable word. Writing the match register arms a one-shot run. The run length is the distance from the base value to the new match value. The base is the counter value captured when the previous run finished. If the new match is at or below the base, the distance wraps through the top of the 32-bit range. A fixed-rate tick advances the run, and `TICK_DIV` clock cycles make one tick: with a 100 MHz clock and the default of 2, the tick rate is 50 MHz. When the run finishes, the base takes the match value and counting stops. If the enable word is nonzero, the status flag is set and the interrupt line goes high and stays high until software writes zero to the status register.

The run is controlled by a two-state machine. `ST_IDLE` means no run is active. `ST_COUNT` means a run is counting down its remaining ticks. The transitions are ARM (`ST_IDLE` to `ST_COUNT` on a match write), REARM (`ST_COUNT` to `ST_COUNT` on a match write, which reloads the run), EXPIRE (`ST_COUNT` to `ST_IDLE` when no ticks remain and no match write is present) and STEP (`ST_COUNT` to `ST_COUNT` on a tick, which decrements the remaining count). The bus is a single-cycle access: a write takes effect at the clock edge that samples `bus_wr`, and read data follows `bus_addr` combinationally while `bus_rd` is high.

Top module: `oneshot_match_timer`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low and no run is active.
- R2: Only word-aligned offsets are decoded. 0x10 reads the counter. 0x14 reads the status flag in bit 0 with the other bits zero. 0x1C reads and writes the 32-bit enable word. 0x00 accepts match writes and reads zero. All other offsets, including unaligned ones, read zero, and writes to them (or to 0x10) have no effect.
- R3: A match write of value M with base B sets the run length to M-B ticks when M>B. Otherwise the length is M+(2^32-1-B) ticks, taken modulo 2^32.
- R4: A counter read returns M minus the ticks still remaining, modulo 2^32. While idle, it returns the base.
- R5: One tick occurs every `TICK_DIV` clock cycles. During a run, each tick lowers the remaining count by one.
- R6: When the remaining count is zero in `ST_COUNT`, the run expires on the next clock edge. The base becomes M, the machine returns to `ST_IDLE`, and the counter then reads M constantly.
- R7: An expiry sets the status flag and raises `irq` only when the enable word is nonzero. With the enable word at zero, an expiry leaves both unchanged.
- R8: `irq` equals the status flag. The flag holds until a status write carrying zero clears it. A status write with nonzero data is ignored.
- R9: A match write during a run restarts the run from the unchanged base, and the ticks already counted are discarded.
- R10: When a match write falls on the same cycle as an expiry, the write wins: the run restarts from the old base and no expiry is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq | output | 1 | Level interrupt, high while the status flag is set |

## Verification
The hardest case to reach is a match write that lands in exactly the cycle in which a run expires. The tick phase cannot be seen at the ports. The bench therefore arms a three-tick run and sweeps the delay before a second match write across a window that spans the expiry. After each attempt it reads the counter at once, which shows the base the new run started from, and reads the status flag. The two must agree: either an old base with no flag, or the old match as base with the flag set. The bench also checks that the restarted run finishes at the new match. Separate directed runs set the base so that the new match is below or equal to it, and check the wrap distance through the first counter read.

// File: rtl/omt_pkg.sv
package omt_pkg;

    localparam int unsigned OMT_DW = 32;

    localparam int unsigned OFS_MATCH  = 32'h00;
    localparam int unsigned OFS_COUNT  = 32'h10;
    localparam int unsigned OFS_STATUS = 32'h14;
    localparam int unsigned OFS_IRQEN  = 32'h1C;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/omt_tick_gen.sv
module omt_tick_gen #(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int unsigned CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            logic [CW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = (phase_q == LAST);

            // R5: ticks are never back to back when the divider exceeds one
            p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/omt_run_ctrl.sv
module omt_run_ctrl
    import omt_pkg::*;
#(
    parameter int unsigned W = OMT_DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] new_match,
    input  logic [W-1:0] base,
    output logic [W-1:0] remaining,
    output logic         expire
);

    run_state_e   state_q, state_d;
    logic [W-1:0] rem_d;
    logic [W-1:0] reload;

    // distance from the base to the new match, wrapping through all-ones
    always_comb begin
        if (new_match > base) begin
            reload = new_match - base;
        end else begin
            reload = new_match + ~base;
        end
    end

    // next state and next remaining count
    always_comb begin
        state_d = state_q;
        rem_d   = remaining;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin                 // ARM
                    state_d = ST_COUNT;
                    rem_d   = reload;
                end
            end
            ST_COUNT: begin
                if (load) begin                 // REARM
                    state_d = ST_COUNT;
                    rem_d   = reload;
                end else if (remaining == '0) begin  // EXPIRE
                    state_d = ST_IDLE;
                end else if (tick) begin        // STEP
                    rem_d = remaining - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                rem_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            remaining <= '0;
        end else begin
            state_q   <= state_d;
            remaining <= rem_d;
        end
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            ST_IDLE:  expire = 1'b0;
            ST_COUNT: expire = (remaining == '0) && !load;
            default:  expire = 1'b0;
        endcase
    end

    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (new_match > base)) |=> (remaining == $past(new_match) - $past(base)));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && !load && remaining != '0)
            |=> (remaining == $past(remaining) - W'(1)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (state_q == ST_IDLE && remaining == '0));

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_COUNT));

endmodule

// File: rtl/omt_regs.sv
module omt_regs
    import omt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned W      = OMT_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              expire,
    input  logic [W-1:0]      remaining,
    output logic [W-1:0]      bus_rdata,
    output logic              load,
    output logic [W-1:0]      match_q,
    output logic [W-1:0]      base_q,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);

    logic         flag_q;
    logic [W-1:0] ien_q;
    logic         wr_status;
    logic         wr_ien;
    logic         mapped_rd;

    assign load      = bus_wr && (bus_addr == A_MATCH);
    assign wr_status = bus_wr && (bus_addr == A_STATUS);
    assign wr_ien    = bus_wr && (bus_addr == A_IRQEN);
    assign mapped_rd = (bus_addr == A_COUNT) || (bus_addr == A_STATUS) ||
                       (bus_addr == A_IRQEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            base_q  <= '0;
            ien_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (load) begin
                match_q <= bus_wdata;
            end
            if (expire) begin
                base_q <= match_q;
            end
            if (wr_ien) begin
                ien_q <= bus_wdata;
            end
            if (expire && (ien_q != '0)) begin
                flag_q <= 1'b1;
            end else if (wr_status && (bus_wdata == '0)) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_COUNT) begin
                bus_rdata = match_q - remaining;
            end else if (bus_addr == A_STATUS) begin
                bus_rdata = {{(W-1){1'b0}}, flag_q};
            end else if (bus_addr == A_IRQEN) begin
                bus_rdata = ien_q;
            end
        end
    end

    assign irq = flag_q;

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped_rd) |-> (bus_rdata == '0));

    p_latch_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (base_q == $past(match_q)));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ien_q != '0) |=> (irq && flag_q));

    p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ien_q == '0 && !flag_q) |=> !irq);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && bus_wdata == '0 && !expire) |=> !irq);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_status && bus_wdata == '0)) |=> irq);

    p_no_flag_on_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flag_q) |=> !irq);

    p_base_kept_on_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $stable(base_q));

endmodule

// File: rtl/oneshot_match_timer.sv
module oneshot_match_timer
    import omt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int unsigned W = OMT_DW;

    logic         tick;
    logic         load;
    logic         expire;
    logic [W-1:0] remaining;
    logic [W-1:0] match_q;
    logic [W-1:0] base_q;

    omt_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    omt_run_ctrl #(
        .W (W)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .new_match (bus_wdata),
        .base      (base_q),
        .remaining (remaining),
        .expire    (expire)
    );

    omt_regs #(
        .ADDR_W (ADDR_W),
        .W      (W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .remaining (remaining),
        .bus_rdata (bus_rdata),
        .load      (load),
        .match_q   (match_q),
        .base_q    (base_q),
        .irq       (irq)
    );

endmodule

// File: tb/oneshot_match_timer_bench.sv
module oneshot_match_timer_bench;

    localparam logic [7:0] A_MATCH  = 8'h00;
    localparam logic [7:0] A_COUNT  = 8'h10;
    localparam logic [7:0] A_STATUS = 8'h14;
    localparam logic [7:0] A_IRQEN  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [31:0] exp_base = 32'h0;
    bit          exp_flag = 1'b0;
    logic [31:0] cur_ien  = 32'h0;

    always #5 clk = ~clk;

    oneshot_match_timer #(.ADDR_W(8), .TICK_DIV(2)) u_oneshot_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] run_len(input logic [31:0] m, input logic [31:0] b);
        if (m > b) return m - b;
        return m + (32'hFFFF_FFFF - b);
    endfunction

    function automatic logic [31:0] first_read(input logic [31:0] m, input logic [31:0] b);
        return m - run_len(m, b);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic set_ien(input logic [31:0] v);
        bus_write(A_IRQEN, v);
        cur_ien = v;
    endtask

    task automatic clear_flag();
        bus_write(A_STATUS, 32'h0);
        exp_flag = 1'b0;
    endtask

    // arm a short forward run and follow it to its end
    task automatic run_to_expiry(input logic [31:0] m, input string tag);
        logic [31:0] rd;
        logic [31:0] len;
        len = run_len(m, exp_base);
        bus_write(A_MATCH, m);
        bus_read(A_COUNT, rd);
        check32({tag, " R3/R4 first counter read"}, rd, first_read(m, exp_base));
        wait_cyc(2 * int'(len) + 6);
        bus_read(A_COUNT, rd);
        check32({tag, " R6 counter at match after expiry"}, rd, m);
        exp_base = m;
        if (cur_ien != 32'h0) exp_flag = 1'b1;
        bus_read(A_STATUS, rd);
        check32({tag, " R7 status after expiry"}, rd, {31'h0, exp_flag});
        check32({tag, " R8 irq follows status"}, {31'h0, irq}, {31'h0, exp_flag});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] m;
        bit saw_early;
        bit saw_late;

        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        bus_read(A_COUNT, rd);  check32("R1 counter", rd, 32'h0);
        bus_read(A_STATUS, rd); check32("R1 status", rd, 32'h0);
        bus_read(A_IRQEN, rd);  check32("R1 enable", rd, 32'h0);
        check32("R1 irq", {31'h0, irq}, 32'h0);

        // R2: register map
        set_ien(32'hA5A5_0001);
        bus_read(A_IRQEN, rd); check32("R2 enable readback", rd, 32'hA5A5_0001);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h12, 32'h1234_5678);
        bus_write(A_COUNT, 32'h0000_0777);
        bus_read(8'h04, rd);    check32("R2 unmapped read", rd, 32'h0);
        bus_read(8'h1D, rd);    check32("R2 unaligned read", rd, 32'h0);
        bus_read(A_COUNT, rd);  check32("R2 counter unaffected by writes", rd, 32'h0);
        bus_read(A_STATUS, rd); check32("R2 status unaffected by writes", rd, 32'h0);
        bus_read(A_IRQEN, rd);  check32("R2 enable unaffected by writes", rd, 32'hA5A5_0001);

        // R7: disabled expiry leaves flag and irq low
        set_ien(32'h0);
        run_to_expiry(32'd12, "disabled");
        bus_read(A_MATCH, rd);  check32("R2 match reads zero", rd, 32'h0);

        // R7/R8: enabled expiry, nonzero status write ignored, zero write clears
        set_ien(32'h0000_0100);
        run_to_expiry(32'd30, "enabled");
        bus_write(A_STATUS, 32'h5);
        bus_read(A_STATUS, rd); check32("R8 nonzero status write ignored", rd, 32'h1);
        check32("R8 irq held", {31'h0, irq}, 32'h1);
        clear_flag();
        bus_read(A_STATUS, rd); check32("R8 zero write clears", rd, 32'h0);
        check32("R8 irq released", {31'h0, irq}, 32'h0);
        clear_flag();
        check32("R8 second clear harmless", {31'h0, irq}, 32'h0);

        // R5: tick rate, 20 clocks give 10 ticks
        bus_write(A_MATCH, exp_base + 32'd40);
        bus_read(A_COUNT, rd); check32("R5 start of run", rd, exp_base);
        wait_cyc(20);
        bus_read(A_COUNT, rd); check32("R5 ten ticks in twenty cycles", rd, exp_base + 32'd10);
        wait_cyc(80);
        exp_base = exp_base + 32'd40;
        exp_flag = 1'b1;
        bus_read(A_COUNT, rd); check32("R6 counter stopped at match", rd, exp_base);
        wait_cyc(10);
        bus_read(A_COUNT, rd); check32("R6 counter stays stopped", rd, exp_base);
        clear_flag();

        // R9: restart during a long run keeps the base
        bus_write(A_MATCH, exp_base + 32'h1000_0000);
        wait_cyc(12);
        bus_read(A_COUNT, rd); check32("R9 long run progressing", rd, exp_base + 32'd6);
        run_to_expiry(exp_base + 32'd8, "R9 restart");
        clear_flag();

        // R3: wrap when the new match is below or equal to the base
        m = exp_base - 32'd2;
        bus_write(A_MATCH, m);
        bus_read(A_COUNT, rd); check32("R3 wrap below base", rd, exp_base + 32'd1);
        wait_cyc(20);
        check32("R3 wrapped run does not expire early", {31'h0, irq}, 32'h0);
        bus_write(A_MATCH, exp_base);
        bus_read(A_COUNT, rd); check32("R3 wrap equal to base", rd, first_read(exp_base, exp_base));
        run_to_expiry(exp_base + 32'd6, "R3 recover");
        clear_flag();

        // random runs
        for (int i = 0; i < 24; i++) begin
            logic [31:0] d;
            d = 32'd1 + ($urandom % 32'd30);
            if (($urandom % 3) == 0) set_ien(32'h0);
            else set_ien($urandom | 32'h8);
            if (exp_flag && (($urandom % 2) == 0)) begin
                bus_write(A_STATUS, ($urandom % 32'd255) + 32'd1);
                bus_read(A_STATUS, rd); check32("R8 random nonzero write ignored", rd, 32'h1);
            end
            if (($urandom % 2) == 0) clear_flag();
            if (($urandom % 4) == 0) begin
                bus_write(A_MATCH, exp_base + 32'h0100_0000 + $urandom % 32'd1000);
                wait_cyc(1 + int'($urandom % 32'd9));
            end
            run_to_expiry(exp_base + d, "random R9");
        end

        // R10: sweep a second match write across the expiry cycle
        set_ien(32'h1);
        clear_flag();
        saw_early = 1'b0;
        saw_late  = 1'b0;
        for (int k = 0; k < 9; k++) begin
            logic [31:0] m1;
            logic [31:0] m2;
            logic [31:0] seen_base;
            logic [31:0] st;
            m1 = exp_base + 32'd3;
            m2 = exp_base + 32'd23;
            bus_write(A_MATCH, m1);
            wait_cyc(k);
            bus_write(A_MATCH, m2);
            bus_read(A_COUNT, seen_base);
            bus_read(A_STATUS, st);
            if (seen_base == exp_base && st == 32'h0) saw_early = 1'b1;
            else if (seen_base == m1 && st == 32'h1) saw_late = 1'b1;
            else check32("R10 base and flag consistent", {seen_base[30:0], st[0]}, {exp_base[30:0], 1'b0});
            wait_cyc(2 * int'(run_len(m2, seen_base)) + 6);
            bus_read(A_COUNT, rd); check32("R10 restarted run ends at new match", rd, m2);
            bus_read(A_STATUS, rd); check32("R10 flag after restarted run", rd, 32'h1);
            exp_base = m2;
            clear_flag();
        end
        check32("R10 both sides of expiry reached", {30'h0, saw_early, saw_late}, 32'h3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule